// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write port and read port each run on their own clock. The two clocks may be unrelated or may be the same clock. Both pointers move as Gray code and reach the opposite domain through a chain of synchronizing flops. The full condition is computed on the write side and the empty condition on the read side, so each flag is registered on its own port's clock.

One core provides two read timings. A select input is sampled while reset is held and is then frozen. With the select high the block runs in standard mode: the write flag reports full, the read flag reports empty, and a word is placed on the read data output only on the edge that accepts a read. With the select low the block runs in fall-through mode: the write flag reports that a slot is free, the read flag reports that a valid word is waiting, and the head word moves into the output register without any request. Every transfer must be qualified by an active-low chip select and an active-high enable on its port. A read-side output enable stands in for a tri-state pad.

Top module: `dmf_top`

## Requirements
- R1: The timing mode is latched from `mode_sel` while `rst_n` is low (1 = standard, 0 = fall-through). Later changes of `mode_sel` have no effect until the next reset.
- R2: A write or a read request is taken on a rising edge of its port clock only when that port's `*_cs_n` is 0 and `*_en` is 1. Any other combination leaves the stored contents and the read output unchanged.
- R3: In standard mode `wr_flag` = 1 means full. It rises on the write edge that fills the last of the 2**ADDR_W slots. A write attempted while full is dropped and stored data is not overwritten.
- R4: In fall-through mode `wr_flag` = 1 means a write will be accepted. The total capacity is 2**ADDR_W memory slots plus the output register, which is 17 words at the default size.
- R5: In standard mode `rd_flag` = 1 means empty. A read attempted while empty is ignored, and the read pointer does not advance.
- R6: In standard mode `rd_data` changes only on the edge that accepts a read, and it then shows the oldest unread word. Otherwise it holds its value.
- R7: In fall-through mode, once the first word of an empty FIFO has crossed into the read domain, it appears on `rd_data` with `rd_flag` = 1 and no read request.
- R8: In fall-through mode a read is accepted only while `rd_flag` = 1. It replaces the head with the next word, or it drops `rd_flag` when nothing else is stored. While no read is accepted, the head and `rd_flag` hold.
- R9: `rd_oe` is 1 exactly when `rd_cs_n` is 0.
- R10: Words leave in the order they were written, with unrelated clocks. Each pointer changes by at most one bit per clock of its own domain.
- R11: After reset the block is empty. In standard mode `wr_flag` = 0 and `rd_flag` = 1. In fall-through mode `wr_flag` = 1 and `rd_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains; the mode is latched while low |
| mode_sel | input | 1 | Timing mode select: 1 standard, 0 fall-through |
| wr_clk | input | 1 | Write port clock |
| wr_cs_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write port enable, active high |
| wr_data | input | DATA_W | Word to store |
| wr_flag | output | 1 | Full in standard mode; slot free in fall-through mode |
| rd_clk | input | 1 | Read port clock |
| rd_cs_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read port enable, active high |
| rd_data | output | DATA_W | Registered read word |
| rd_oe | output | 1 | Output enable for the read data pads |
| rd_flag | output | 1 | Empty in standard mode; output ready in fall-through mode |

## Verification
The bound checker watches, on every clock, the properties that span a single domain. These are: no pointer motion on a dropped write or read, one-step advance on an accepted standard read, a stable output word between accepted reads, a held head in fall-through mode, and single-bit Gray steps. What only the directed scenarios can show is behaviour that crosses domains. That covers when a first word falls through, the 17-word fall-through capacity, word order under two unrelated clocks, and the reset-time mode capture with its effect on the meaning of each flag.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

   typedef enum logic {
      MODE_FWFT = 1'b0,
      MODE_STD  = 1'b1
   } dmf_mode_e;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
   parameter int AW = 4,
   parameter int DW = 18
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl #(
   parameter int AW = 4
) (
   input  logic        wr_clk,
   input  logic        rst_n,
   input  logic        wr_req,
   input  logic [AW:0] rq_gray,
   output logic        wr_fire,
   output logic [AW:0] w_bin,
   output logic [AW:0] w_gray,
   output logic        full
);

   import dmf_pkg::*;

   logic [AW:0] bin_nx;
   logic [AW:0] gray_nx;
   logic [AW:0] full_mark;
   logic [31:0] gray_wide;

   assign wr_fire   = wr_req & ~full;
   assign bin_nx    = w_bin + {{AW{1'b0}}, wr_fire};
   assign gray_wide = bin2gray(32'(bin_nx));
   assign gray_nx   = gray_wide[AW:0];
   assign full_mark = {~rq_gray[AW:AW-1], rq_gray[AW-2:0]};

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         w_bin  <= '0;
         w_gray <= '0;
         full   <= 1'b0;
      end else begin
         w_bin  <= bin_nx;
         w_gray <= gray_nx;
         full   <= (gray_nx == full_mark);
      end
   end

endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl #(
   parameter int AW = 4,
   parameter int DW = 18
) (
   input  logic               rd_clk,
   input  logic               rst_n,
   input  dmf_pkg::dmf_mode_e mode,
   input  logic               rd_req,
   input  logic [AW:0]        wq_gray,
   input  logic [DW-1:0]      mem_q,
   output logic [AW:0]        r_bin,
   output logic [AW:0]        r_gray,
   output logic               mem_empty,
   output logic               out_valid,
   output logic [DW-1:0]      rd_data
);

   import dmf_pkg::*;

   logic        pop;
   logic        take;
   logic [AW:0] bin_nx;
   logic [AW:0] gray_nx;
   logic [31:0] gray_wide;

   // take: the consumer accepts the head word in fall-through mode
   assign take = rd_req & out_valid;

   always_comb begin
      if (mode == MODE_STD) pop = rd_req & ~mem_empty;
      else                  pop = ~mem_empty & (~out_valid | take);
   end

   assign bin_nx    = r_bin + {{AW{1'b0}}, pop};
   assign gray_wide = bin2gray(32'(bin_nx));
   assign gray_nx   = gray_wide[AW:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         r_bin     <= '0;
         r_gray    <= '0;
         mem_empty <= 1'b1;
         rd_data   <= '0;
         out_valid <= 1'b0;
      end else begin
         r_bin     <= bin_nx;
         r_gray    <= gray_nx;
         mem_empty <= (gray_nx == wq_gray);
         if (pop) rd_data <= mem_q;
         if (mode == MODE_STD) out_valid <= 1'b0;
         else if (pop)         out_valid <= 1'b1;
         else if (take)        out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/dmf_top.sv
module dmf_top #(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              mode_sel,
   input  logic              wr_clk,
   input  logic              wr_cs_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_flag,
   input  logic              rd_clk,
   input  logic              rd_cs_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              rd_flag
);

   import dmf_pkg::*;

   localparam int PTR_W = ADDR_W + 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dmf_top: ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dmf_top: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dmf_top: DATA_W must be at least 1");
      end
   endgenerate

   dmf_mode_e       wr_mode;
   dmf_mode_e       rd_mode;
   logic            wr_std;
   logic            rd_std;
   logic [PTR_W-1:0] w_bin, w_gray, r_bin, r_gray, wq_gray, rq_gray;
   logic            wr_fire, full, mem_empty, out_valid;
   logic [DATA_W-1:0] mem_q;

   // mode is captured per domain while reset is held, then frozen
   always_ff @(posedge wr_clk) begin
      if (!rst_n) wr_mode <= dmf_mode_e'(mode_sel);
   end
   always_ff @(posedge rd_clk) begin
      if (!rst_n) rd_mode <= dmf_mode_e'(mode_sel);
   end

   assign wr_std = (wr_mode == MODE_STD);
   assign rd_std = (rd_mode == MODE_STD);

   dmf_wr_ctrl #(.AW(ADDR_W)) u_wr (
      .wr_clk  (wr_clk),
      .rst_n   (rst_n),
      .wr_req  (~wr_cs_n & wr_en),
      .rq_gray (rq_gray),
      .wr_fire (wr_fire),
      .w_bin   (w_bin),
      .w_gray  (w_gray),
      .full    (full)
   );

   dmf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (r_gray),
      .q     (rq_gray)
   );

   dmf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (w_gray),
      .q     (wq_gray)
   );

   dmf_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .wclk  (wr_clk),
      .we    (wr_fire),
      .waddr (w_bin[ADDR_W-1:0]),
      .wdata (wr_data),
      .raddr (r_bin[ADDR_W-1:0]),
      .rdata (mem_q)
   );

   dmf_rd_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
      .rd_clk    (rd_clk),
      .rst_n     (rst_n),
      .mode      (rd_mode),
      .rd_req    (~rd_cs_n & rd_en),
      .wq_gray   (wq_gray),
      .mem_q     (mem_q),
      .r_bin     (r_bin),
      .r_gray    (r_gray),
      .mem_empty (mem_empty),
      .out_valid (out_valid),
      .rd_data   (rd_data)
   );

   assign wr_flag = wr_std ? full      : ~full;
   assign rd_flag = rd_std ? mem_empty : out_valid;
   assign rd_oe   = ~rd_cs_n;

endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
   parameter int AW = 4,
   parameter int DW = 18
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wr_std,
   input logic          rd_std,
   input logic          wr_cs_n,
   input logic          wr_en,
   input logic          rd_cs_n,
   input logic          rd_en,
   input logic          wr_flag,
   input logic          rd_flag,
   input logic [DW-1:0] rd_data,
   input logic [AW:0]   w_bin,
   input logic [AW:0]   w_gray,
   input logic [AW:0]   r_bin,
   input logic [AW:0]   r_gray
);

   logic wreq, rreq;
   assign wreq = ~wr_cs_n & wr_en;
   assign rreq = ~rd_cs_n & rd_en;

   AST_IDLE_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wreq |=> $stable(w_bin)); // R2

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_std && wr_flag && wreq) |=> $stable(w_bin)); // R3

   AST_FWFT_WRITE_GATED: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!wr_std && !wr_flag && wreq) |=> $stable(w_bin)); // R4

   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_std && rd_flag && rreq) |=> $stable(r_bin)); // R5

   AST_STD_READ_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_std && !rd_flag && rreq) |=> (r_bin == $past(r_bin) + 1'b1)); // R6

   AST_STD_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_std && !(rreq && !rd_flag)) |=> $stable(rd_data)); // R6

   AST_FWFT_HEAD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!rd_std && rd_flag && !rreq) |=> (rd_flag && $stable(rd_data))); // R8

   AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(w_gray ^ $past(w_gray)) <= 1); // R10

   AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $countones(r_gray ^ $past(r_gray)) <= 1); // R10

endmodule

bind dmf_top dmf_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
   .wr_clk  (wr_clk),
   .rd_clk  (rd_clk),
   .rst_n   (rst_n),
   .wr_std  (wr_std),
   .rd_std  (rd_std),
   .wr_cs_n (wr_cs_n),
   .wr_en   (wr_en),
   .rd_cs_n (rd_cs_n),
   .rd_en   (rd_en),
   .wr_flag (wr_flag),
   .rd_flag (rd_flag),
   .rd_data (rd_data),
   .w_bin   (w_bin),
   .w_gray  (w_gray),
   .r_bin   (r_bin),
   .r_gray  (r_gray)
);

// File: tb/tb_dmf_top.sv
`timescale 1ns/1ps
module tb_dmf_top;

   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = 14;
   localparam int DW         = 18;
   localparam int AW         = 4;
   localparam int DEPTH      = 1 << AW;

   logic          rst_n = 1'b0;
   logic          mode_sel = 1'b1;
   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          wr_cs_n = 1'b1;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_cs_n = 1'b1;
   logic          rd_en = 1'b0;
   logic          wr_flag, rd_flag, rd_oe;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

   dmf_top #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
      .rst_n   (rst_n),
      .mode_sel(mode_sel),
      .wr_clk  (wr_clk),
      .wr_cs_n (wr_cs_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .wr_flag (wr_flag),
      .rd_clk  (rd_clk),
      .rd_cs_n (rd_cs_n),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .rd_oe   (rd_oe),
      .rd_flag (rd_flag)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_rd(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   task automatic do_reset(input logic std);
      rst_n = 1'b0; mode_sel = std;
      wr_cs_n = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b1; rd_en = 1'b0;
      repeat (4) @(posedge rd_clk);
      repeat (2) @(posedge wr_clk);
      @(negedge wr_clk) rst_n = 1'b1;
      wait_rd(2);
   endtask

   task automatic wr_raw(input logic [DW-1:0] d, input logic cs_n, input logic en);
      @(negedge wr_clk);
      wr_cs_n = cs_n; wr_en = en; wr_data = d;
      @(negedge wr_clk);
      wr_cs_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic rd_raw(input logic cs_n, input logic en);
      @(negedge rd_clk);
      rd_cs_n = cs_n; rd_en = en;
      @(negedge rd_clk);
      rd_cs_n = 1'b1; rd_en = 1'b0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 30 && !rd_flag; i++) @(negedge rd_clk);
   endtask

   task automatic t_std_basic();
      do_reset(1'b1);
      chk(wr_flag == 1'b0, "R11 R1 std wr_flag after reset", wr_flag, 0);
      chk(rd_flag == 1'b1, "R11 R1 std rd_flag after reset", rd_flag, 1);
      mode_sel = 1'b0;   // change after reset must not alter the mode (R1)
      wr_raw(18'h0AA, 1'b0, 1'b0);
      wr_raw(18'h0BB, 1'b1, 1'b1);
      wait_rd(8);
      chk(rd_flag == 1'b1, "R2 unqualified writes ignored", rd_flag, 1);
      wr_raw(18'h101, 1'b0, 1'b1);
      wr_raw(18'h102, 1'b0, 1'b1);
      wr_raw(18'h103, 1'b0, 1'b1);
      wait_rd(8);
      chk(rd_flag == 1'b0, "R5 R1 not empty after writes", rd_flag, 0);
      chk(rd_data == '0, "R6 no data before read", rd_data, 0);
      @(negedge rd_clk); rd_cs_n = 1'b1; #1;
      chk(rd_oe == 1'b0, "R9 oe low when deselected", rd_oe, 0);
      rd_cs_n = 1'b0; #1;
      chk(rd_oe == 1'b1, "R9 oe high when selected", rd_oe, 1);
      rd_cs_n = 1'b1;
      rd_raw(1'b0, 1'b0);
      chk(rd_data == '0, "R2 read without enable ignored", rd_data, 0);
      rd_raw(1'b0, 1'b1);
      chk(rd_data == 18'h101, "R6 first read", rd_data, 18'h101);
      wait_rd(3);
      chk(rd_data == 18'h101, "R6 data held between reads", rd_data, 18'h101);
      rd_raw(1'b0, 1'b1);
      chk(rd_data == 18'h102, "R10 order second", rd_data, 18'h102);
      rd_raw(1'b0, 1'b1);
      chk(rd_data == 18'h103, "R10 order third", rd_data, 18'h103);
      chk(rd_flag == 1'b1, "R5 empty after last read", rd_flag, 1);
      rd_raw(1'b0, 1'b1);
      chk(rd_data == 18'h103, "R5 read while empty ignored", rd_data, 18'h103);
      wr_raw(18'h1AB, 1'b0, 1'b1);
      wait_rd(8);
      rd_raw(1'b0, 1'b1);
      chk(rd_data == 18'h1AB, "R5 pointer unmoved by empty read", rd_data, 18'h1AB);
   endtask

   task automatic t_std_full();
      do_reset(1'b1);
      for (int k = 0; k < DEPTH; k++) wr_raw(DW'(18'h200 + k), 1'b0, 1'b1);
      chk(wr_flag == 1'b1, "R3 full after last slot", wr_flag, 1);
      wr_raw(18'h3FF, 1'b0, 1'b1);
      wait_rd(8);
      for (int k = 0; k < DEPTH; k++) begin
         rd_raw(1'b0, 1'b1);
         chk(rd_data == DW'(18'h200 + k), "R3 R10 full drain order", rd_data, 18'h200 + k);
      end
      chk(rd_flag == 1'b1, "R3 write while full dropped", rd_flag, 1);
      repeat (8) @(negedge wr_clk);
      chk(wr_flag == 1'b0, "R3 full clears after drain", wr_flag, 0);
   endtask

   task automatic t_fwft_basic();
      do_reset(1'b0);
      chk(wr_flag == 1'b1, "R11 R1 fwft wr_flag after reset", wr_flag, 1);
      chk(rd_flag == 1'b0, "R11 R1 fwft rd_flag after reset", rd_flag, 0);
      wr_raw(18'h055, 1'b0, 1'b1);
      wait_ready();
      chk(rd_flag == 1'b1, "R7 head falls through", rd_flag, 1);
      chk(rd_data == 18'h055, "R7 head data without read", rd_data, 18'h055);
      rd_raw(1'b1, 1'b1);
      chk(rd_flag == 1'b1, "R2 deselected read ignored", rd_flag, 1);
      rd_raw(1'b0, 1'b1);
      chk(rd_flag == 1'b0, "R8 flag drops when nothing follows", rd_flag, 0);
      for (int k = 0; k < 3; k++) wr_raw(DW'(18'h061 + k), 1'b0, 1'b1);
      for (int k = 0; k < 3; k++) begin
         wait_ready();
         chk(rd_data == DW'(18'h061 + k), "R8 gated read sequence", rd_data, 18'h061 + k);
         rd_raw(1'b0, 1'b1);
      end
      wait_rd(8);
      chk(rd_flag == 1'b0, "R8 empty after gated reads", rd_flag, 0);
   endtask

   task automatic t_fwft_fill();
      int n = 0;
      do_reset(1'b0);
      for (int c = 0; c < 80; c++) begin
         @(negedge wr_clk);
         if (wr_flag && n < 40) begin
            wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = DW'(18'h400 + n); n++;
         end else begin
            wr_cs_n = 1'b1; wr_en = 1'b0;
         end
      end
      @(negedge wr_clk); wr_cs_n = 1'b1; wr_en = 1'b0;
      chk(n == DEPTH + 1, "R4 fall-through capacity", n, DEPTH + 1);
      chk(wr_flag == 1'b0, "R4 no space when full", wr_flag, 0);
      for (int k = 0; k < DEPTH + 1; k++) begin
         wait_ready();
         chk(rd_data == DW'(18'h400 + k), "R10 fall-through drain order", rd_data, 18'h400 + k);
         rd_raw(1'b0, 1'b1);
      end
   endtask

   task automatic t_std_stream();
      do_reset(1'b1);
      fork
         begin
            int n = 0;
            while (n < 30) begin
               @(negedge wr_clk);
               if (!wr_flag) begin
                  wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = DW'(18'h300 + n); n++;
               end else begin
                  wr_cs_n = 1'b1; wr_en = 1'b0;
               end
            end
            @(negedge wr_clk); wr_cs_n = 1'b1; wr_en = 1'b0;
         end
         begin
            int got = 0;
            while (got < 30) begin
               @(negedge rd_clk);
               if (!rd_flag) begin
                  rd_cs_n = 1'b0; rd_en = 1'b1;
                  @(negedge rd_clk);
                  rd_cs_n = 1'b1; rd_en = 1'b0;
                  chk(rd_data == DW'(18'h300 + got), "R10 stream order", rd_data, 18'h300 + got);
                  got++;
               end
            end
         end
      join
   endtask

   initial begin
      fork
         begin
            t_std_basic();
            t_std_full();
            t_fwft_basic();
            t_fwft_fill();
            t_std_stream();
         end
         begin
            repeat (150000) @(posedge wr_clk);
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule